// File: doc/BRIEF.md
# Vector-Type Dependency Pre-Decode Scanner

This block looks at a whole fetch bundle of instruction words before the main decoder sees them. It finds the instructions that set the vector type and tags every slot with the closest earlier slot in the same bundle that wrote the vector type. The vector type covers element width, register grouping, and the tail and mask policies. With these tags the rename stage can link each vector instruction to the right producer while the main decoder stays free of state. A slot with no earlier writer in the bundle takes the vector type that was in force before the bundle arrived.

The block is combinational and holds no state. Every output follows the current inputs in the same cycle. It also raises a coarse per-slot hint that the instruction may be a control transfer, based only on the major opcode. It reports at bundle level whether any valid slot writes the vector type, and which such slot is last. A parameter chooses one of two structures for the prior-writer search: a ripple chain or a per-slot priority scan. Both give the same results.

Top module: `vtype_prescan`

## Requirements
- R1: All outputs are a pure function of the present `insn_i` and `valid_i`. Applying the same bundle again after a different one gives identical outputs, with no cycle of latency.
- R2: A valid slot is flagged in `is_vset_o` when its opcode bits [6:0] equal 7'h57, its bits [14:12] equal 3'b111, and either bit 31 is 0, or bits [31:30] are 2'b11, or bits [31:25] are 7'b1000000.
- R3: For each valid slot i, `has_prior_o[i]` is 1 exactly when some valid slot j < i writes the vector type. `prior_idx_o[i*3 +: 3]` then holds the largest such j.
- R4: `bundle_vset_o` is 1 when any valid slot writes the vector type. `last_vset_o` then gives the highest such slot index, and is 0 otherwise.
- R5: `may_branch_o[i]` is 1 for a valid slot whose opcode bits [6:0] are 7'h63, 7'h6F or 7'h67, and 0 for any other opcode.
- R6: A slot whose `valid_i` bit is 0 has all of its annotations at 0. Its contents never act as a vector-type writer for later slots or for the bundle summary.
- R7: An instruction with opcode 7'h57 is not a writer if its bits [14:12] differ from 3'b111, or if bit 31 is 1 and bits [31:25] are neither 2'b11x_xxxx nor 7'b1000000.
- R8: Slot 0 never reports a prior writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 256 | Eight instruction words; slot k occupies bits [k*32 +: 32] |
| valid_i | input | 8 | Per-slot valid mask |
| is_vset_o | output | 8 | Slot writes the vector type |
| may_branch_o | output | 8 | Opcode-only control-transfer hint |
| has_prior_o | output | 8 | An earlier valid slot in the bundle writes the vector type |
| prior_idx_o | output | 24 | Per-slot 3-bit index of the nearest earlier writer |
| bundle_vset_o | output | 1 | Any valid slot writes the vector type |
| last_vset_o | output | 3 | Index of the highest writing slot |

## Verification
The hardest case to reach is a writer hidden in an invalid slot that lies between two valid writers. The nearest-writer search must skip it and point back to the older valid writer, and it must also be left out of the bundle's last-writer index. The stimulus builds bundles where writer encodings fill slots whose valid bits are cleared. One such bundle places an invalid writer in the top slot, so the last-writer index has to fall back to a lower slot. The bench also sends near-miss encodings that carry the vector opcode, covering each of the three writer forms and their rejected neighbours.

// File: rtl/vtscan_pkg.sv
package vtscan_pkg;
   localparam logic [6:0] OPC_VEC    = 7'h57;
   localparam logic [6:0] OPC_BRANCH = 7'h63;
   localparam logic [6:0] OPC_JAL    = 7'h6F;
   localparam logic [6:0] OPC_JALR   = 7'h67;
   localparam logic [2:0] F3_CFG     = 3'b111;
   localparam logic [6:0] F7_VSETVL  = 7'b1000000;

   typedef enum logic [1:0] {
      VS_NONE  = 2'd0,
      VS_VLI   = 2'd1,
      VS_IVLI  = 2'd2,
      VS_VL    = 2'd3
   } vset_form_e;

   function automatic vset_form_e classify_vset(input logic [31:0] w);
      vset_form_e f;
      f = VS_NONE;
      if (w[6:0] == OPC_VEC && w[14:12] == F3_CFG) begin
         if (!w[31])                   f = VS_VLI;
         else if (w[30])               f = VS_IVLI;
         else if (w[31:25] == F7_VSETVL) f = VS_VL;
      end
      return f;
   endfunction
endpackage

// File: rtl/vtscan_slot_classify.sv
module vtscan_slot_classify
   import vtscan_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic [INSN_W-1:0] insn_i,
   input  logic              valid_i,
   output logic              is_vset_o,
   output logic              may_branch_o
);
   vset_form_e form;
   logic [6:0] opc;

   always_comb begin
      form = classify_vset(insn_i[31:0]);
      opc  = insn_i[6:0];
      is_vset_o    = valid_i && (form != VS_NONE);
      may_branch_o = valid_i && ((opc == OPC_BRANCH) || (opc == OPC_JAL) ||
                                 (opc == OPC_JALR));
   end
endmodule

// File: rtl/vtscan_prior_find.sv
module vtscan_prior_find #(
   parameter int NUM_SLOTS = 8,
   parameter bit RIPPLE    = 1'b1,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0]       writer_i,
   input  logic [NUM_SLOTS-1:0]       valid_i,
   output logic [NUM_SLOTS-1:0]       has_prior_o,
   output logic [NUM_SLOTS*IDX_W-1:0] prior_idx_o
);
   logic [NUM_SLOTS-1:0]       seen;
   logic [NUM_SLOTS*IDX_W-1:0] idx_raw;

   if (RIPPLE) begin : g_ripple
      assign seen[0] = 1'b0;
      assign idx_raw[0 +: IDX_W] = '0;
      for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_stage
         assign seen[i] = seen[i-1] | writer_i[i-1];
         assign idx_raw[i*IDX_W +: IDX_W] = writer_i[i-1] ? IDX_W'(i-1)
                                           : idx_raw[(i-1)*IDX_W +: IDX_W];
      end
   end else begin : g_scan
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         always_comb begin
            seen[i] = 1'b0;
            idx_raw[i*IDX_W +: IDX_W] = '0;
            for (int j = 0; j < i; j++) begin
               if (writer_i[j]) begin
                  seen[i] = 1'b1;
                  idx_raw[i*IDX_W +: IDX_W] = IDX_W'(j);
               end
            end
         end
      end
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
      assign has_prior_o[i] = valid_i[i] & seen[i];
      assign prior_idx_o[i*IDX_W +: IDX_W] = has_prior_o[i] ?
                                              idx_raw[i*IDX_W +: IDX_W] : '0;
   end
endmodule

// File: rtl/vtscan_last_find.sv
module vtscan_last_find #(
   parameter int NUM_SLOTS = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0] writer_i,
   output logic                 any_o,
   output logic [IDX_W-1:0]     last_o
);
   always_comb begin
      any_o  = |writer_i;
      last_o = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (writer_i[k]) last_o = IDX_W'(k);
      end
   end
endmodule

// File: rtl/vtype_prescan.sv
module vtype_prescan #(
   parameter int NUM_SLOTS = 8,
   parameter int INSN_W    = 32,
   parameter bit RIPPLE    = 1'b1,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS*INSN_W-1:0] insn_i,
   input  logic [NUM_SLOTS-1:0]        valid_i,
   output logic [NUM_SLOTS-1:0]        is_vset_o,
   output logic [NUM_SLOTS-1:0]        may_branch_o,
   output logic [NUM_SLOTS-1:0]        has_prior_o,
   output logic [NUM_SLOTS*IDX_W-1:0]  prior_idx_o,
   output logic                        bundle_vset_o,
   output logic [IDX_W-1:0]            last_vset_o
);
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("vtype_prescan: NUM_SLOTS must be at least 2");
   end
   if (INSN_W != 32) begin : g_bad_width
      $error("vtype_prescan: INSN_W must be 32");
   end

   logic [NUM_SLOTS-1:0] writer;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cls
      vtscan_slot_classify #(.INSN_W(INSN_W)) u_cls (
         .insn_i       (insn_i[s*INSN_W +: INSN_W]),
         .valid_i      (valid_i[s]),
         .is_vset_o    (writer[s]),
         .may_branch_o (may_branch_o[s])
      );
   end

   assign is_vset_o = writer;

   vtscan_prior_find #(.NUM_SLOTS(NUM_SLOTS), .RIPPLE(RIPPLE)) u_prior (
      .writer_i    (writer),
      .valid_i     (valid_i),
      .has_prior_o (has_prior_o),
      .prior_idx_o (prior_idx_o)
   );

   vtscan_last_find #(.NUM_SLOTS(NUM_SLOTS)) u_last (
      .writer_i (writer),
      .any_o    (bundle_vset_o),
      .last_o   (last_vset_o)
   );
endmodule

// File: rtl/vtype_prescan_chk.sv
module vtype_prescan_chk #(
   parameter int NUM_SLOTS = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic [NUM_SLOTS-1:0]       valid_i,
   input logic [NUM_SLOTS-1:0]       is_vset_o,
   input logic [NUM_SLOTS-1:0]       may_branch_o,
   input logic [NUM_SLOTS-1:0]       has_prior_o,
   input logic [NUM_SLOTS*IDX_W-1:0] prior_idx_o,
   input logic                       bundle_vset_o,
   input logic [IDX_W-1:0]           last_vset_o
);
   always_comb begin
      // R8
      slot0_no_prior_chk: assert final (!has_prior_o[0]);
      // R4
      bundle_any_chk: assert final (bundle_vset_o == (|is_vset_o));
      // R4
      last_is_writer_chk: assert final (!bundle_vset_o || is_vset_o[last_vset_o]);
      // R4
      last_zero_idle_chk: assert final (bundle_vset_o || last_vset_o == '0);
      for (int i = 0; i < NUM_SLOTS; i++) begin
         // R6
         invalid_quiet_chk: assert final (valid_i[i] ||
            (!is_vset_o[i] && !may_branch_o[i] && !has_prior_o[i] &&
             prior_idx_o[i*IDX_W +: IDX_W] == '0));
         // R3
         prior_points_back_chk: assert final (!has_prior_o[i] ||
            (int'(prior_idx_o[i*IDX_W +: IDX_W]) < i &&
             is_vset_o[prior_idx_o[i*IDX_W +: IDX_W]]));
         // R4
         last_is_highest_chk: assert final (!(bundle_vset_o && is_vset_o[i]) ||
            i <= int'(last_vset_o));
      end
   end
endmodule

bind vtype_prescan vtype_prescan_chk #(.NUM_SLOTS(NUM_SLOTS)) u_vtype_prescan_chk (
   .valid_i       (valid_i),
   .is_vset_o     (is_vset_o),
   .may_branch_o  (may_branch_o),
   .has_prior_o   (has_prior_o),
   .prior_idx_o   (prior_idx_o),
   .bundle_vset_o (bundle_vset_o),
   .last_vset_o   (last_vset_o)
);

// File: tb/vtype_prescan_bench.sv
module vtype_prescan_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int IW = 3;

   typedef struct {
      logic [N-1:0]    vset;
      logic [N-1:0]    br;
      logic [N-1:0]    hp;
      logic [N*IW-1:0] pidx;
      logic            any;
      logic [IW-1:0]   last;
      string           tag;
   } exp_t;

   logic clk = 1'b0;
   logic [N*32-1:0] insn;
   logic [N-1:0]    valid;
   logic [N-1:0]    is_vset, may_br, has_pr;
   logic [N*IW-1:0] pidx;
   logic            bany;
   logic [IW-1:0]   blast;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vtype_prescan u_vtype_prescan (
      .insn_i (insn), .valid_i (valid),
      .is_vset_o (is_vset), .may_branch_o (may_br),
      .has_prior_o (has_pr), .prior_idx_o (pidx),
      .bundle_vset_o (bany), .last_vset_o (blast)
   );

   localparam logic [31:0] NOP   = 32'h0000_0013;
   localparam logic [31:0] VLI   = {1'b0, 11'h0D0, 5'd10, 3'b111, 5'd5, 7'h57};
   localparam logic [31:0] IVLI  = {2'b11, 10'h0D8, 5'd4, 3'b111, 5'd6, 7'h57};
   localparam logic [31:0] VL    = {7'b1000000, 5'd3, 5'd2, 3'b111, 5'd1, 7'h57};
   localparam logic [31:0] BADVL = {7'b1000001, 5'd3, 5'd2, 3'b111, 5'd1, 7'h57};
   localparam logic [31:0] VADD  = {7'b0000001, 5'd3, 5'd2, 3'b000, 5'd1, 7'h57};
   localparam logic [31:0] BEQ   = 32'h0000_0063;
   localparam logic [31:0] JAL   = 32'h0000_006F;
   localparam logic [31:0] JALR  = 32'h0000_0067;

   // Independent reference from the requirement text
   function automatic exp_t model(input logic [N*32-1:0] w, input logic [N-1:0] v,
                                  input string tag);
      exp_t e;
      logic [31:0] x;
      logic wr;
      int lastw;
      e.vset = '0; e.br = '0; e.hp = '0; e.pidx = '0; e.any = 1'b0; e.last = '0;
      e.tag = tag;
      lastw = -1;
      for (int i = 0; i < N; i++) begin
         x = w[i*32 +: 32];
         wr = v[i] && x[6:0] == 7'h57 && x[14:12] == 3'b111 &&
              (x[31] == 1'b0 || x[31:30] == 2'b11 || x[31:25] == 7'b1000000);
         if (v[i] && lastw >= 0) begin
            e.hp[i] = 1'b1;
            e.pidx[i*IW +: IW] = IW'(lastw);
         end
         e.vset[i] = wr;
         e.br[i] = v[i] && (x[6:0] == 7'h63 || x[6:0] == 7'h6F || x[6:0] == 7'h67);
         if (wr) begin
            lastw = i;
            e.any = 1'b1;
            e.last = IW'(i);
         end
      end
      return e;
   endfunction

   task automatic drive(input logic [N*32-1:0] w, input logic [N-1:0] v,
                        input string tag);
      @(posedge clk);
      insn  = w;
      valid = v;
      q.push_back(model(w, v, tag));
   endtask

   task automatic cmp(input string req, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, tag, act, exp);
      end
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            e = q.pop_front();
            cmp("R2", e.tag, 32'(is_vset), 32'(e.vset));
            cmp("R5", e.tag, 32'(may_br),  32'(e.br));
            cmp("R3", e.tag, 32'(has_pr),  32'(e.hp));
            cmp("R3", e.tag, 32'(pidx),    32'(e.pidx));
            cmp("R4", e.tag, 32'(bany),    32'(e.any));
            cmp("R4", e.tag, 32'(blast),   32'(e.last));
         end
      end
   end

   function automatic logic [N*32-1:0] pack(input logic [31:0] s0, s1, s2, s3,
                                            s4, s5, s6, s7);
      return {s7, s6, s5, s4, s3, s2, s1, s0};
   endfunction

   initial begin : stim
      insn = '0; valid = '0;
      // R6: idle bundle, everything quiet
      drive(pack(VLI, VLI, VLI, VLI, VLI, VLI, VLI, VLI), 8'h00, "R6_all_invalid");
      // no vset at all
      drive(pack(NOP, BEQ, NOP, JAL, NOP, JALR, NOP, VADD), 8'hFF, "R5_no_vset");
      // R8: writer in slot 0 feeds every later slot
      drive(pack(VLI, NOP, NOP, NOP, NOP, NOP, NOP, NOP), 8'hFF, "R8_slot0");
      // R2: three forms, nearest wins (R3)
      drive(pack(NOP, VLI, NOP, IVLI, BEQ, VL, NOP, NOP), 8'hFF, "R3_several");
      // R7: near misses are not writers
      drive(pack(VADD, BADVL, NOP, NOP, NOP, NOP, NOP, BADVL), 8'hFF, "R7_nearmiss");
      // R6: invalid writers skipped, including top slot for R4
      drive(pack(VLI, NOP, IVLI, NOP, VL, NOP, NOP, VLI), 8'b0110_1011, "R6_hidden");
      // R6: invalid branch slots give no hint
      drive(pack(BEQ, JAL, JALR, VL, NOP, NOP, NOP, NOP), 8'b1111_0000, "R6_inv_branch");
      // writer in top slot only
      drive(pack(NOP, NOP, NOP, NOP, NOP, NOP, NOP, IVLI), 8'hFF, "R4_top");
      // R1: same bundle again after another, no history
      drive(pack(NOP, VLI, NOP, IVLI, BEQ, VL, NOP, NOP), 8'hFF, "R1_repeat");
      drive(pack(VL, VL, VL, VL, VL, VL, VL, VL), 8'hFF, "R3_all_writers");
      drive(pack(NOP, NOP, NOP, NOP, NOP, NOP, NOP, NOP), 8'h00, "R1_back_idle");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
   end

   initial begin : watchdog
      for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule